// File: doc/BRIEF.md
# General-Purpose I/O Port Pin Output Controller

This block is the digital control for one general-purpose I/O port of `PW` pins (eight by default). Software programs a per-pin data latch and a per-pin drive-style register. For each pin the block then produces an output enable, a drive value and a weak pull-up enable for the pad. A drive-style bit of 1 selects push-pull. A bit of 0 selects open-drain, in which the pad is driven only when the pin should be low. An open-drain pin whose latch holds 1 is therefore free to act as an input.

An external memory bus can take over the pins without touching the drive-style register. While an access is in progress, the bus supplies the output values in place of the latch. During a bus read, the pins that carry the data bus have their drivers turned off. A small state machine tracks the bus activity. It has three named states: `ST_IDLE`, `ST_BUS_WR` and `ST_BUS_RD`. Its transitions are:
- `ST_IDLE` moves to `ST_BUS_WR` when valid is high with the read flag low.
- `ST_IDLE` moves to `ST_BUS_RD` when valid is high with the read flag high.
- `ST_BUS_WR` and `ST_BUS_RD` cross to each other when the read flag changes while valid stays high.
- Either bus state returns to `ST_IDLE` when valid falls.

The state machine registers the bus value and the data-bus mask as it moves. Pad inputs pass through a two-flop synchronizer before software can read them.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset the latch reads all ones, the drive-style register reads 0 (every pin open-drain), the control register reads 0, `pin_oe` is 0 and `pin_pu` is all ones.
- R2: A pin whose drive-style bit is 1 (push-pull) has `pin_oe` high and `pin_do` equal to its effective output value.
- R3: A pin whose drive-style bit is 0 (open-drain) has `pin_oe` high only when its effective output value is 0. With a latch value of 1 it is not driven.
- R4: The weak pull-up is on by default. Writing 1 to bit 0 of the control register (address 3) turns off the pull-ups of all pins. Writing 0 turns them back on.
- R5: The pull-up of any pin that is actively driving 0 (`pin_oe`=1, `pin_do`=0) is off.
- R6: In the cycle after a clock edge samples `bus_valid` high with `bus_rd` low, `pin_do` equals the sampled `bus_val`, and the drive styles still follow the drive-style register, which is left unchanged.
- R7: In the cycle after a clock edge samples `bus_valid` and `bus_rd` high, pins whose `bus_dmask` bit is 1 have `pin_oe` 0. The other pins drive `bus_val` according to their drive style.
- R8: Reading address 0 returns the pad levels `pin_in` as sampled two clock edges earlier.
- R9: Address 1 reads back the latch, address 2 the drive-style register, and address 3 the control register with bit 0 as the pull-up disable and all other bits 0.
- R10: A write to address 0 updates the latch at the next clock edge. If the write happens during a bus access, the pins keep the bus values until the edge that samples `bus_valid` low, and then show the new latch value.
- R11: A write to address 1 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 port, 1 latch, 2 drive style, 3 control) |
| cfg_wdata | input | PW | Register write data |
| cfg_rdata | output | PW | Register read data for `cfg_addr` |
| pin_in | input | PW | Pad input levels |
| bus_valid | input | 1 | External memory access in progress |
| bus_rd | input | 1 | External memory access is a read |
| bus_val | input | PW | Address/data value the bus drives |
| bus_dmask | input | PW | 1 marks pins that carry the data bus |
| pin_oe | output | PW | Per-pin output enable |
| pin_do | output | PW | Per-pin drive value |
| pin_pu | output | PW | Per-pin weak pull-up enable |

## Verification
The bench builds the block with the default width of eight pins. At that width it can use masks that split the port into nibbles, so push-pull and open-drain pins are checked side by side in one cycle. Bus data masks cover only part of the port, so in a single read access the bench sees disabled data-bus pins and still-driven address pins. The same width lets every pin pattern be written and read back in full through the register interface.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADR_W = 2;

    localparam logic [ADR_W-1:0] ADR_PORT  = 2'd0;
    localparam logic [ADR_W-1:0] ADR_LATCH = 2'd1;
    localparam logic [ADR_W-1:0] ADR_MODE  = 2'd2;
    localparam logic [ADR_W-1:0] ADR_CTRL  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUS_WR = 2'd1,
        ST_BUS_RD = 2'd2
    } bus_st_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] raw_i,
    output logic [PW-1:0] sync_o
);

    logic [PW-1:0] meta_q;
    logic [PW-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [ADR_W-1:0] addr_i,
    input  logic [PW-1:0]    wdata_i,
    input  logic [PW-1:0]    pads_i,
    output logic [PW-1:0]    rdata_o,
    output logic [PW-1:0]    latch_o,
    output logic [PW-1:0]    mode_o,
    output logic             pud_o
);

    logic [PW-1:0] latch_q;
    logic [PW-1:0] mode_q;
    logic          pud_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            mode_q  <= '0;
            pud_q   <= 1'b0;
        end else if (wr_i) begin
            unique case (addr_i)
                ADR_PORT:  latch_q <= wdata_i;
                ADR_MODE:  mode_q  <= wdata_i;
                ADR_CTRL:  pud_q   <= wdata_i[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            ADR_PORT:  rdata_o = pads_i;
            ADR_LATCH: rdata_o = latch_q;
            ADR_MODE:  rdata_o = mode_q;
            default:   rdata_o = {{(PW-1){1'b0}}, pud_q};
        endcase
    end

    assign latch_o = latch_q;
    assign mode_o  = mode_q;
    assign pud_o   = pud_q;

    AST_LATCH_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_PORT) |=> (latch_q == $past(wdata_i))); // R10

    AST_LATCH_ADDR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_LATCH) |=> ($stable(latch_q) && $stable(mode_q) && $stable(pud_q))); // R11

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          rd_i,
    input  logic [PW-1:0] val_i,
    input  logic [PW-1:0] dmask_i,
    output logic          act_o,
    output logic          rd_act_o,
    output logic [PW-1:0] val_o,
    output logic [PW-1:0] dmask_o
);

    bus_st_e       st_q;
    bus_st_e       st_d;
    logic [PW-1:0] val_q;
    logic [PW-1:0] dmask_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (valid_i) st_d = rd_i ? ST_BUS_RD : ST_BUS_WR;
            end
            ST_BUS_WR: begin
                if (!valid_i)  st_d = ST_IDLE;
                else if (rd_i) st_d = ST_BUS_RD;
            end
            ST_BUS_RD: begin
                if (!valid_i)   st_d = ST_IDLE;
                else if (!rd_i) st_d = ST_BUS_WR;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            val_q   <= '0;
            dmask_q <= '0;
        end else begin
            st_q <= st_d;
            if (valid_i) begin
                val_q   <= val_i;
                dmask_q <= dmask_i;
            end
        end
    end

    always_comb begin
        act_o    = 1'b0;
        rd_act_o = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_BUS_WR: act_o = 1'b1;
            ST_BUS_RD: begin
                act_o    = 1'b1;
                rd_act_o = 1'b1;
            end
            default:   ;
        endcase
    end

    assign val_o   = val_q;
    assign dmask_o = dmask_q;

    AST_BUS_STATE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> $past(valid_i)); // R6

    AST_BUS_RD_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUS_RD) |-> $past(rd_i)); // R7

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] latch_i,
    input  logic [PW-1:0] mode_i,
    input  logic          pud_i,
    input  logic          bus_act_i,
    input  logic          bus_rd_i,
    input  logic [PW-1:0] bus_val_i,
    input  logic [PW-1:0] bus_dmask_i,
    output logic [PW-1:0] oe_o,
    output logic [PW-1:0] do_o,
    output logic [PW-1:0] pu_o
);

    for (genvar g = 0; g < PW; g++) begin : g_pin
        logic eff;
        logic off;
        logic oe;

        always_comb begin
            eff = bus_act_i ? bus_val_i[g] : latch_i[g];
            off = bus_rd_i & bus_dmask_i[g];
            if (off)            oe = 1'b0;
            else if (mode_i[g]) oe = 1'b1;
            else                oe = ~eff;
        end

        assign oe_o[g] = oe;
        assign do_o[g] = eff;
        assign pu_o[g] = ~pud_i & ~(oe & ~eff);
    end

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [PW-1:0]    cfg_wdata,
    output logic [PW-1:0]    cfg_rdata,
    input  logic [PW-1:0]    pin_in,
    input  logic             bus_valid,
    input  logic             bus_rd,
    input  logic [PW-1:0]    bus_val,
    input  logic [PW-1:0]    bus_dmask,
    output logic [PW-1:0]    pin_oe,
    output logic [PW-1:0]    pin_do,
    output logic [PW-1:0]    pin_pu
);

    logic [PW-1:0] pads_s;
    logic [PW-1:0] latch_s;
    logic [PW-1:0] mode_s;
    logic          pud_s;
    logic          act_s;
    logic          rd_act_s;
    logic [PW-1:0] bval_s;
    logic [PW-1:0] bmask_s;

    gpio_in_sync #(.PW(PW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pads_s)
    );

    gpio_cfg_regs #(.PW(PW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .pads_i  (pads_s),
        .rdata_o (cfg_rdata),
        .latch_o (latch_s),
        .mode_o  (mode_s),
        .pud_o   (pud_s)
    );

    gpio_bus_fsm #(.PW(PW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (bus_valid),
        .rd_i     (bus_rd),
        .val_i    (bus_val),
        .dmask_i  (bus_dmask),
        .act_o    (act_s),
        .rd_act_o (rd_act_s),
        .val_o    (bval_s),
        .dmask_o  (bmask_s)
    );

    gpio_pin_drive #(.PW(PW)) u_drive (
        .latch_i     (latch_s),
        .mode_i      (mode_s),
        .pud_i       (pud_s),
        .bus_act_i   (act_s),
        .bus_rd_i    (rd_act_s),
        .bus_val_i   (bval_s),
        .bus_dmask_i (bmask_s),
        .oe_o        (pin_oe),
        .do_o        (pin_do),
        .pu_o        (pin_pu)
    );

    AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act_s |-> ((mode_s & ~pin_oe) == '0)); // R2

    AST_OD_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode_s & pin_oe & pin_do) == '0)); // R3

    AST_PUD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pud_s |-> (pin_pu == '0)); // R4

    AST_PU_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pu & pin_oe & ~pin_do) == '0)); // R5

    AST_MODE_KEPT_IN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_s && !$past(cfg_wr)) |-> $stable(mode_s)); // R6

    AST_RD_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act_s |-> ((pin_oe & bmask_s) == '0)); // R7

    AST_IDLE_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !act_s |-> (pin_do == latch_s)); // R10

endmodule

// File: tb/sim_gpio_pin_ctl.sv
module sim_gpio_pin_ctl;

    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic [PW-1:0] cfg_rdata;
    logic [PW-1:0] pin_in = '0;
    logic          bus_valid = 1'b0;
    logic          bus_rd = 1'b0;
    logic [PW-1:0] bus_val = '0;
    logic [PW-1:0] bus_dmask = '0;
    logic [PW-1:0] pin_oe;
    logic [PW-1:0] pin_do;
    logic [PW-1:0] pin_pu;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    gpio_pin_ctl #(.PW(PW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_in    (pin_in),
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_val   (bus_val),
        .bus_dmask (bus_dmask),
        .pin_oe    (pin_oe),
        .pin_do    (pin_do),
        .pin_pu    (pin_pu)
    );

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [PW-1:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [PW-1:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [PW-1:0] r;
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pu", pin_pu, 8'hFF);
        reg_read(2'd1, r); check("R1 latch", r, 8'hFF);
        reg_read(2'd2, r); check("R1 mode", r, 8'h00);
        reg_read(2'd3, r); check("R1 ctrl", r, 8'h00);
    endtask

    task automatic t_push_pull;
        logic [PW-1:0] r;
        reg_write(2'd2, 8'hFF);
        reg_write(2'd0, 8'hA5);
        check("R2 oe", pin_oe, 8'hFF);
        check("R2 do", pin_do, 8'hA5);
        check("R5 pu pp", pin_pu, 8'hA5);
        reg_read(2'd1, r); check("R9 latch", r, 8'hA5);
        reg_read(2'd2, r); check("R9 mode", r, 8'hFF);
    endtask

    task automatic t_open_drain;
        reg_write(2'd2, 8'h0F);
        reg_write(2'd0, 8'h3C);
        check("R3 oe mixed", pin_oe, 8'hCF);
        check("R3 do mixed", pin_do, 8'h3C);
        check("R5 pu mixed", pin_pu, 8'h3C);
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, 8'hFF);
        check("R3 input pins", pin_oe, 8'h00);
    endtask

    task automatic t_pullup_disable;
        logic [PW-1:0] r;
        reg_write(2'd3, 8'hFF);
        check("R4 pu off", pin_pu, 8'h00);
        reg_read(2'd3, r); check("R9 ctrl", r, 8'h01);
        reg_write(2'd3, 8'h00);
        check("R4 pu back", pin_pu, 8'hFF);
    endtask

    task automatic t_sync;
        logic [PW-1:0] r;
        @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk);
        reg_read(2'd0, r); check("R8 one edge", r, 8'h00);
        @(negedge clk);
        reg_read(2'd0, r); check("R8 two edges", r, 8'h5A);
    endtask

    task automatic t_latch_addr_ro;
        logic [PW-1:0] r;
        reg_write(2'd0, 8'h96);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, r); check("R11 latch kept", r, 8'h96);
        reg_read(2'd2, r); check("R11 mode kept", r, 8'h00);
        check("R11 pins kept", pin_do, 8'h96);
    endtask

    task automatic t_bus_write;
        logic [PW-1:0] r;
        reg_write(2'd2, 8'h0F);
        reg_write(2'd0, 8'hFF);
        @(negedge clk);
        bus_valid = 1'b1; bus_rd = 1'b0; bus_val = 8'h12; bus_dmask = 8'hFF;
        @(negedge clk);
        check("R6 do", pin_do, 8'h12);
        check("R6 oe", pin_oe, 8'hEF);
        reg_read(2'd2, r); check("R6 mode kept", r, 8'h0F);
        reg_write(2'd0, 8'h00);
        check("R10 pins hold", pin_do, 8'h12);
        reg_read(2'd1, r); check("R10 latch upd", r, 8'h00);
        bus_valid = 1'b0;
        @(negedge clk);
        check("R10 do after", pin_do, 8'h00);
        check("R10 oe after", pin_oe, 8'hFF);
    endtask

    task automatic t_bus_read;
        reg_write(2'd2, 8'hFF);
        reg_write(2'd0, 8'hAA);
        @(negedge clk);
        bus_valid = 1'b1; bus_rd = 1'b1; bus_val = 8'h34; bus_dmask = 8'h0F;
        @(negedge clk);
        check("R7 oe", pin_oe, 8'hF0);
        check("R7 do", pin_do, 8'h34);
        bus_valid = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        check("R7 oe after", pin_oe, 8'hFF);
        check("R7 do after", pin_do, 8'hAA);
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pull();
        t_open_drain();
        t_pullup_disable();
        t_sync();
        t_latch_addr_ro();
        t_bus_write();
        t_bus_read();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule